// File: doc/BRIEF.md
# Dual-Path Storage Bus Transceiver

This block joins two 18-bit buses, called A and B, through two independent one-way lanes. The A-to-B lane stores a copy of the A input and presents it on the B port. The B-to-A lane does the same in the opposite direction. Each lane has one storage register, and three controls decide how that register behaves:

- **Latch enable.** While it is high, the register follows its input.
- **Capture clock.** While the latch enable is low, the register holds its value. It takes a new value only when this clock goes from high to low.
- **Output enable.** This decides whether the port drives. The A-to-B enable is active high. The B-to-A enable is active low.

The whole block runs from one fast system clock, `clk`. The lane controls are sampled as ordinary inputs on that clock. A falling edge of the capture clock is detected by comparing its current sample with the state kept from the previous sample.

Each lane runs a four-state machine. The state records two things about the previous sample: whether the lane was open (latch enable high) or shut, and whether the capture clock was low or high.

| State | Meaning |
|---|---|
| `ST_OPEN_LO` | Open, capture clock was low |
| `ST_OPEN_HI` | Open, capture clock was high |
| `ST_SHUT_LO` | Shut, capture clock was low |
| `ST_SHUT_HI` | Shut, capture clock was high |

On every clock the machine moves to the state that matches the current sample of the latch enable and capture clock. The transitions are named as follows:

| Transition | When it happens | Effect on the register |
|---|---|---|
| *follow* | into either open state | loads |
| *grab* | from an `_HI` state into `ST_SHUT_LO` | loads |
| *arm* | from `ST_SHUT_LO` to `ST_SHUT_HI` | none |
| *idle* | shut, with the clock level unchanged | none |

Reset puts the machine in `ST_SHUT_LO`. The data registers themselves have no reset.

Each port is modelled as three separate signals: an input vector, an output vector, and a per-bit drive vector. When a port is disabled, its output vector reads zero.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_out` shows the value of `a_in` from the previous `clk` edge, with every bit unchanged and in place. The path is 18 bits wide and non-inverting.
- R2: While `le_ab` is low and `cp_ab` keeps the same level on consecutive samples, the A-to-B stored value does not change.
- R3: When `le_ab` is low and `cp_ab` is sampled high and then low on the next edge, the A-to-B register takes the `a_in` value present at that second edge.
- R4: A low-to-high change of `cp_ab` while `le_ab` is low leaves the stored value unchanged.
- R5: When `oe_ab` is 1, `b_drv` is all ones and `b_out` carries the stored value. When `oe_ab` is 0, both `b_drv` and `b_out` are zero in the same cycle.
- R6: When `oe_ba_n` is 0, `a_drv` is all ones and `a_out` carries the B-to-A stored value. When `oe_ba_n` is 1, both `a_drv` and `a_out` are zero.
- R7: The B-to-A lane follows rules R1 to R4, using `b_in`, `le_ba` and `cp_ba`. It is unaffected by the A-to-B controls.
- R8: When both lanes are enabled together, both ports drive at the same time, each with its own stored value.
- R9: A falling `cp_ab` while `le_ab` is high has no effect beyond the normal following of the input.
- R10: If `le_ab` goes low on the same edge at which `cp_ab` falls from a high sample, the A-to-B register captures `a_in` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset of the lane state machines |
| a_in | input | 18 | Data received from bus A |
| b_in | input | 18 | Data received from bus B |
| le_ab | input | 1 | A-to-B latch enable, high = follow |
| cp_ab | input | 1 | A-to-B capture clock, captures on falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = follow |
| cp_ba | input | 1 | B-to-A capture clock, captures on falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Value driven onto bus B, zero when disabled |
| b_drv | output | 18 | Per-bit drive enable for bus B |
| a_out | output | 18 | Value driven onto bus A, zero when disabled |
| a_drv | output | 18 | Per-bit drive enable for bus A |

## Verification
A change to a lane's stored value shows up one `clk` edge after the inputs are sampled. The output enables, by contrast, act on `a_out`, `b_out`, `a_drv` and `b_drv` within the same cycle. The bench therefore drives new inputs on the falling edge of `clk`. On the following falling edge it first checks the result of the rising edge in between, and only then applies the next stimulus. Its reference model takes the previous capture-clock level from the prior step, which mirrors the one-edge memory the state machine keeps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Lane state: open/shut = latch enable level, LO/HI = last capture-clock sample
    typedef enum logic [1:0] {
        ST_OPEN_LO = 2'b00,
        ST_OPEN_HI = 2'b01,
        ST_SHUT_LO = 2'b10,
        ST_SHUT_HI = 2'b11
    } lane_state_e;

    // Output-enable polarity of a lane
    typedef enum logic {
        POL_ACT_HIGH = 1'b0,
        POL_ACT_LOW  = 1'b1
    } en_pol_e;

endpackage

// File: rtl/lane_fsm.sv
module lane_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le,
    input  logic cp,
    output logic load
);

    lane_state_e state_q;
    lane_state_e state_d;

    // next state: always the current sample of (le, cp)
    always_comb begin
        unique case ({le, cp})
            2'b10:   state_d = ST_OPEN_LO;
            2'b11:   state_d = ST_OPEN_HI;
            2'b01:   state_d = ST_SHUT_HI;
            default: state_d = ST_SHUT_LO;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUT_LO;
        else        state_q <= state_d;
    end

    // outputs: follow when open, grab when leaving a high capture-clock state
    always_comb begin
        unique case (state_q)
            ST_OPEN_HI, ST_SHUT_HI: load = le | ~cp;
            ST_OPEN_LO, ST_SHUT_LO: load = le;
            default:                load = le;
        endcase
    end

endmodule

// File: rtl/lane_store.sv
module lane_store #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // no reset: contents undefined until first load
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end

endmodule

// File: rtl/lane_drive.sv
module lane_drive
    import xcvr_pkg::*;
#(
    parameter int unsigned W   = 18,
    parameter en_pol_e     POL = POL_ACT_HIGH
) (
    input  logic         en_raw,
    input  logic [W-1:0] q,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv
);

    logic en;

    generate
        if (POL == POL_ACT_LOW) begin : g_low
            assign en = ~en_raw;
        end else begin : g_high
            assign en = en_raw;
        end
    endgenerate

    assign drv  = {W{en}};
    assign dout = q & drv;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned W   = 18,
    parameter en_pol_e     POL = POL_ACT_HIGH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         cp,
    input  logic         en_raw,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv
);

    logic         load;
    logic [W-1:0] held;

    lane_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .le   (le),
        .cp   (cp),
        .load (load)
    );

    lane_store #(.W(W)) u_store (
        .clk (clk),
        .load(load),
        .d   (din),
        .q   (held)
    );

    lane_drive #(.W(W), .POL(POL)) u_drive (
        .en_raw(en_raw),
        .q     (held),
        .dout  (dout),
        .drv   (drv)
    );

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         le_ab,
    input  logic         cp_ab,
    input  logic         oe_ab,
    input  logic         le_ba,
    input  logic         cp_ba,
    input  logic         oe_ba_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv
);

    xcvr_lane #(.W(W), .POL(POL_ACT_HIGH)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (a_in),
        .le    (le_ab),
        .cp    (cp_ab),
        .en_raw(oe_ab),
        .dout  (b_out),
        .drv   (b_drv)
    );

    xcvr_lane #(.W(W), .POL(POL_ACT_LOW)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (b_in),
        .le    (le_ba),
        .cp    (cp_ba),
        .en_raw(oe_ba_n),
        .dout  (a_out),
        .drv   (a_drv)
    );

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         le_ab,
    input logic         cp_ab,
    input logic         oe_ab,
    input logic         le_ba,
    input logic         cp_ba,
    input logic         oe_ba_n,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_drv,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_drv
);

    AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(le_ab) && oe_ab) |-> (b_out == $past(a_in))); // R1

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(le_ab) && ($past(cp_ab, 2) == $past(cp_ab)) && oe_ab && $past(oe_ab))
        |-> $stable(b_out)); // R2

    AST_AB_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(le_ab) && $past(cp_ab, 2) && !$past(cp_ab) && oe_ab)
        |-> (b_out == $past(a_in))); // R3

    AST_AB_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(le_ab) && !$past(cp_ab, 2) && $past(cp_ab) && oe_ab && $past(oe_ab))
        |-> $stable(b_out)); // R4

    AST_B_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ab |-> (b_drv == '0 && b_out == '0)); // R5

    AST_B_PORT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ab |-> (b_drv == '1)); // R5

    AST_A_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n |-> (a_drv == '0 && a_out == '0)); // R6

    AST_A_PORT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ba_n |-> (a_drv == '1)); // R6

    AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(le_ba) && !oe_ba_n) |-> (a_out == $past(b_in))); // R7

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (a_in),
    .b_in   (b_in),
    .le_ab  (le_ab),
    .cp_ab  (cp_ab),
    .oe_ab  (oe_ab),
    .le_ba  (le_ba),
    .cp_ba  (cp_ba),
    .oe_ba_n(oe_ba_n),
    .b_out  (b_out),
    .b_drv  (b_drv),
    .a_out  (a_out),
    .a_drv  (a_drv)
);

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;

    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;
    logic [W-1:0] b_out, b_drv, a_out, a_drv;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_path_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .le_ab(le_ab), .cp_ab(cp_ab), .oe_ab(oe_ab),
        .le_ba(le_ba), .cp_ba(cp_ba), .oe_ba_n(oe_ba_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    // reference model state
    logic [W-1:0] exp_ab, exp_ba;
    bit           kn_ab = 1'b0, kn_ba = 1'b0;
    bit           pcp_ab = 1'b0, ple_ab = 1'b0, pcp_ba = 1'b0;
    string        tag_ab, tag_ba;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one step: drive at negedge, check at the following negedge
    task automatic step(input logic lab, cab, oab, lba, cba, oban,
                        input logic [W-1:0] da, db);
        le_ab = lab; cp_ab = cab; oe_ab = oab;
        le_ba = lba; cp_ba = cba; oe_ba_n = oban;
        a_in = da;   b_in = db;
        // A-to-B model
        if (lab) begin
            exp_ab = da; kn_ab = 1'b1;
            tag_ab = (pcp_ab && !cab) ? "R9" : "R1";
        end else if (pcp_ab && !cab) begin
            exp_ab = da; kn_ab = 1'b1;
            tag_ab = ple_ab ? "R10" : "R3";
        end else if (!pcp_ab && cab) tag_ab = "R4";
        else tag_ab = "R2";
        pcp_ab = cab; ple_ab = lab;
        // B-to-A model (R7)
        if (lba || (pcp_ba && !cba)) begin
            exp_ba = db; kn_ba = 1'b1;
        end
        tag_ba = "R7";
        pcp_ba = cba;
        @(negedge clk);
        check("R5 b_drv", b_drv, {W{oab}});
        check("R6 a_drv", a_drv, {W{~oban}});
        if (!oab) check("R5 b_out off", b_out, '0);
        else if (kn_ab) check((oban ? tag_ab : {tag_ab, "/R8"}), b_out, exp_ab);
        if (oban) check("R6 a_out off", a_out, '0);
        else if (kn_ba) check((oab ? {tag_ba, "/R8"} : tag_ba), a_out, exp_ba);
    endtask

    initial begin
        rst_n = 1'b0;
        le_ab = 0; cp_ab = 0; oe_ab = 0;
        le_ba = 0; cp_ba = 0; oe_ba_n = 1;
        a_in = '0; b_in = '0;
        repeat (5) @(negedge clk);
        check("R5 reset b_drv", b_drv, '0);
        check("R6 reset a_drv", a_drv, '0);
        check("R5 reset b_out", b_out, '0);
        check("R6 reset a_out", a_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // near-exhaustive sweep of control combinations, two data passes
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0]   c;
                logic [W-1:0] da, db;
                c  = 8'(i);
                da = W'((i * 40503 + pass * 9973 + 17) ^ (i << 7));
                db = W'((i * 26699 + pass * 31337 + 5) ^ ~(i << 9));
                step(c[0], c[1], c[2] | c[6], c[3], c[4], c[5] & c[7], da, db);
            end
        end
        // directed: bit-walk transparency, both ports on (R1, R8)
        for (int k = 0; k < W; k++)
            step(1, 0, 1, 1, 0, 0, W'(1) << k, ~(W'(1) << k));
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule